// File: doc/BRIEF.md
# Fractional E1 Test-Pattern Generator and Checker

This block places a programmable test pattern into a 2.048 Mbit/s frame of 32 eight-bit timeslots and checks the same kind of pattern coming back. A 32-bit mask picks the timeslots that carry the pattern. The picked timeslots are joined into one continuous bit stream, so a fractional link and a full link are tested the same way. Timeslots outside the mask keep carrying live traffic. The block runs one bit per clock, and a frame pulse marks the first bit of each frame.

The pattern comes from a shift register of up to 32 stages. The length and the feedback tap can both be set. Two pattern modes are available: a pseudo-random sequence, and a fixed word sent over and over. The checker trains itself on the incoming selected bits and declares sync once its predictions hold. While it is in sync, it counts every bit that differs from its prediction. If the error rate becomes too high, it drops sync and trains again. The error counter stops at its maximum value and is cleared by a host write pulse.

Top module: `frac_prbs_engine`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `data_out`, `in_sync` and `err_count` are all 0.
- R2: `frame_pulse` high on a clock marks that bit as bit 0 of timeslot 0. Bits 8t to 8t+7 of a frame belong to timeslot t. Bit t of `slot_mask` set to 1 selects timeslot t. For an unselected bit, `data_out` equals `data_in` one clock later, and the checker ignores that bit.
- R3: With `pat_mode`=0 (pseudo-random), length L=`pat_len` (2..32) and tap T=`pat_tap` (1..L), the generated bits appear on `data_out` one clock after their selected bit positions. Taken in order, they satisfy b(n) = b(n-L) xor b(n-T).
- R4: After a `restart` pulse in pseudo-random mode, the first L generated bits are all 1.
- R5: `pat_invert`=1 inverts every generated bit. The checker removes the inversion before it compares.
- R6: With `pat_mode`=1 (repeating), the generator sends the low L bits of `pat_word` cyclically, bit L-1 first. The checker can sync to such a stream.
- R7: In pseudo-random mode, an all-zero generator register is replaced by the seed value 1, so ones keep appearing even with a degenerate tap. The checker never declares sync while its own register is all zeros.
- R8: `in_sync` rises after 48 consecutive selected bits that match the checker's prediction. A `restart` clears `in_sync` on the next clock.
- R9: While `in_sync` is 1, each mismatching selected bit adds exactly 1 to `err_count`. While `in_sync` is 0, `err_count` does not change.
- R10: Six mismatches within one 64-bit window cause sync to be lost. Windows are counted from the bit where sync was gained. After losing sync, the checker reloads from the incoming bits and can regain sync.
- R11: An `err_clear` pulse sets `err_count` to 0 on the next clock. The clear wins over an error in the same cycle.
- R12: `err_count` stops at all ones (`CNT_W` bits) and stays there until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one frame bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| frame_pulse | input | 1 | Marks bit 0 of timeslot 0 |
| data_in | input | 1 | Incoming line bit |
| data_out | output | 1 | Outgoing bit: pattern or passed-through traffic |
| slot_mask | input | SLOTS | Per-timeslot pattern enable |
| gen_en | input | 1 | Enables insertion of the pattern |
| chk_en | input | 1 | Enables checking of selected bits |
| pat_mode | input | 1 | 0 pseudo-random, 1 repeating word |
| pat_len | input | 6 | Register length L |
| pat_tap | input | 6 | Feedback tap T |
| pat_invert | input | 1 | Inverts the pattern |
| pat_word | input | W | Repeating-mode pattern word |
| restart | input | 1 | Reseeds the generator and drops the checker's sync |
| err_clear | input | 1 | Host write that clears the error counter |
| in_sync | output | 1 | Checker locked to the incoming pattern |
| err_count | output | CNT_W | Saturating bit-error count |

## Verification
The clear and the counter increment can land in the same cycle. To provoke this, the bench drives a corrupted selected bit at the very clock where it pulses `err_clear` while the checker is in sync. It judges the result by requiring `err_count` to read zero afterwards, and a later single error must then read one. A second collision happens when a window's sixth error is counted and sync is dropped at the same edge. The bench provokes it with a burst of consecutive errors and accepts a count rise of between six and eleven, which covers any position of the window boundary, together with `in_sync` low.

// File: rtl/frac_prbs_pkg.sv
package frac_prbs_pkg;
  localparam int PAT_MAX_W = 32;
  localparam int LEN_W     = 6;

  typedef enum logic {
    PAT_PRBS   = 1'b0,
    PAT_REPEAT = 1'b1
  } pat_mode_e;

  typedef struct packed {
    pat_mode_e        mode;
    logic [LEN_W-1:0] len;
    logic [LEN_W-1:0] tap;
    logic             invert;
  } pat_cfg_t;
endpackage

// File: rtl/frac_slot_timer.sv
module frac_slot_timer #(
  parameter int SLOTS     = 32,
  parameter int SLOT_BITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_pulse,
  input  logic [SLOTS-1:0] slot_mask,
  output logic             slot_sel
);
  localparam int FRAME_BITS = SLOTS * SLOT_BITS;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int BIT_W      = $clog2(SLOT_BITS);
  localparam int SLOT_W     = $clog2(SLOTS);

  logic [POS_W-1:0]  pos_q;
  logic [POS_W-1:0]  pos_c;
  logic [SLOT_W-1:0] slot_idx;

  always_comb begin
    if (frame_pulse)
      pos_c = '0;
    else if (pos_q == POS_W'(FRAME_BITS - 1))
      pos_c = '0;
    else
      pos_c = pos_q + 1'b1;
  end

  assign slot_idx = pos_c[POS_W-1:BIT_W];
  assign slot_sel = slot_mask[slot_idx];

  always_ff @(posedge clk) begin
    if (rst) pos_q <= POS_W'(FRAME_BITS - 1);
    else     pos_q <= pos_c;
  end
endmodule

// File: rtl/frac_pat_gen.sv
module frac_pat_gen
  import frac_prbs_pkg::*;
#(
  parameter int W = PAT_MAX_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         advance,
  input  pat_cfg_t     cfg,
  input  logic [W-1:0] len_mask,
  input  logic [W-1:0] pat_word,
  output logic         gen_bit
);
  localparam int IDX_W = $clog2(W);

  logic [W-1:0]     sr_q;
  logic [IDX_W-1:0] msb_idx;
  logic [IDX_W-1:0] tap_idx;
  logic             msb;
  logic             ins;
  logic             zero_state;

  assign msb_idx    = IDX_W'(cfg.len - LEN_W'(1));
  assign tap_idx    = IDX_W'(cfg.tap - LEN_W'(1));
  assign msb        = sr_q[msb_idx];
  assign ins        = (cfg.mode == PAT_REPEAT) ? msb : (msb ^ sr_q[tap_idx]);
  assign zero_state = (cfg.mode == PAT_PRBS) && ((sr_q & len_mask) == '0);
  assign gen_bit    = msb ^ cfg.invert;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '1;
    end else if (restart) begin
      sr_q <= (cfg.mode == PAT_REPEAT) ? (pat_word & len_mask) : len_mask;
    end else if (advance) begin
      if (zero_state) sr_q <= {{(W-1){1'b0}}, 1'b1};
      else            sr_q <= ((sr_q << 1) | {{(W-1){1'b0}}, ins}) & len_mask;
    end
  end
endmodule

// File: rtl/frac_pat_chk.sv
module frac_pat_chk
  import frac_prbs_pkg::*;
#(
  parameter int W         = PAT_MAX_W,
  parameter int CNT_W     = 32,
  parameter int SYNC_BITS = 48,
  parameter int WIN_BITS  = 64,
  parameter int LOSS_ERRS = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             sample,
  input  logic             bit_in,
  input  pat_cfg_t         cfg,
  input  logic [W-1:0]     len_mask,
  input  logic             err_clear,
  output logic             in_sync,
  output logic [CNT_W-1:0] err_count
);
  localparam int IDX_W  = $clog2(W);
  localparam int GOOD_W = $clog2(SYNC_BITS);
  localparam int WIN_W  = $clog2(WIN_BITS);
  localparam int LOSS_W = $clog2(LOSS_ERRS + 1);

  logic [W-1:0]      sr_q;
  logic [GOOD_W-1:0] good_q;
  logic [WIN_W-1:0]  win_q;
  logic [LOSS_W-1:0] werr_q;
  logic [IDX_W-1:0]  msb_idx;
  logic [IDX_W-1:0]  tap_idx;
  logic              rx;
  logic              expb;
  logic              mism;
  logic              zero_state;
  logic              count_inc;

  assign msb_idx    = IDX_W'(cfg.len - LEN_W'(1));
  assign tap_idx    = IDX_W'(cfg.tap - LEN_W'(1));
  assign rx         = bit_in ^ cfg.invert;
  assign expb       = (cfg.mode == PAT_REPEAT) ? sr_q[msb_idx]
                                               : (sr_q[msb_idx] ^ sr_q[tap_idx]);
  assign mism       = rx ^ expb;
  assign zero_state = (cfg.mode == PAT_PRBS) && ((sr_q & len_mask) == '0);
  assign count_inc  = sample && in_sync && mism;

  // Lock state machine: out of sync the register follows the line,
  // in sync it follows its own prediction so a single hit costs one error.
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      sr_q    <= '0;
      good_q  <= '0;
      win_q   <= '0;
      werr_q  <= '0;
      in_sync <= 1'b0;
    end else if (sample) begin
      if (!in_sync) begin
        sr_q <= ((sr_q << 1) | {{(W-1){1'b0}}, rx}) & len_mask;
        if (mism || zero_state) begin
          good_q <= '0;
        end else if (good_q == GOOD_W'(SYNC_BITS - 1)) begin
          good_q  <= '0;
          win_q   <= '0;
          werr_q  <= '0;
          in_sync <= 1'b1;
        end else begin
          good_q <= good_q + 1'b1;
        end
      end else begin
        sr_q <= ((sr_q << 1) | {{(W-1){1'b0}}, expb}) & len_mask;
        if (mism && (werr_q == LOSS_W'(LOSS_ERRS - 1))) begin
          in_sync <= 1'b0;
          good_q  <= '0;
          werr_q  <= '0;
          win_q   <= '0;
        end else if (win_q == WIN_W'(WIN_BITS - 1)) begin
          win_q  <= '0;
          werr_q <= '0;
        end else begin
          win_q  <= win_q + 1'b1;
          werr_q <= werr_q + LOSS_W'(mism);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || err_clear)
      err_count <= '0;
    else if (count_inc && (err_count != '1))
      err_count <= err_count + 1'b1;
  end
endmodule

// File: rtl/frac_prbs_engine.sv
module frac_prbs_engine
  import frac_prbs_pkg::*;
#(
  parameter int W         = PAT_MAX_W,
  parameter int SLOTS     = 32,
  parameter int SLOT_BITS = 8,
  parameter int CNT_W     = 32,
  parameter int SYNC_BITS = 48,
  parameter int WIN_BITS  = 64,
  parameter int LOSS_ERRS = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_pulse,
  input  logic             data_in,
  output logic             data_out,
  input  logic [SLOTS-1:0] slot_mask,
  input  logic             gen_en,
  input  logic             chk_en,
  input  logic             pat_mode,
  input  logic [LEN_W-1:0] pat_len,
  input  logic [LEN_W-1:0] pat_tap,
  input  logic             pat_invert,
  input  logic [W-1:0]     pat_word,
  input  logic             restart,
  input  logic             err_clear,
  output logic             in_sync,
  output logic [CNT_W-1:0] err_count
);
  logic             slot_sel;
  logic [LEN_W-1:0] len_c;
  logic [LEN_W-1:0] tap_c;
  logic [W-1:0]     len_mask;
  pat_cfg_t         cfg;
  logic             gen_bit;
  logic             gen_adv;
  logic             chk_sample;

  always_comb begin
    if (pat_len < LEN_W'(2))      len_c = LEN_W'(2);
    else if (pat_len > LEN_W'(W)) len_c = LEN_W'(W);
    else                          len_c = pat_len;
    if (pat_tap < LEN_W'(1))      tap_c = LEN_W'(1);
    else if (pat_tap > len_c)     tap_c = len_c;
    else                          tap_c = pat_tap;
  end

  for (genvar gi = 0; gi < W; gi++) begin : g_len_mask
    assign len_mask[gi] = (LEN_W'(gi) < len_c);
  end

  assign cfg.mode   = pat_mode_e'(pat_mode);
  assign cfg.len    = len_c;
  assign cfg.tap    = tap_c;
  assign cfg.invert = pat_invert;

  assign gen_adv    = gen_en && slot_sel && !restart;
  assign chk_sample = chk_en && slot_sel && !restart;

  frac_slot_timer #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .frame_pulse (frame_pulse),
    .slot_mask   (slot_mask),
    .slot_sel    (slot_sel)
  );

  frac_pat_gen #(.W(W)) u_gen (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .advance  (gen_adv),
    .cfg      (cfg),
    .len_mask (len_mask),
    .pat_word (pat_word),
    .gen_bit  (gen_bit)
  );

  frac_pat_chk #(
    .W(W), .CNT_W(CNT_W), .SYNC_BITS(SYNC_BITS),
    .WIN_BITS(WIN_BITS), .LOSS_ERRS(LOSS_ERRS)
  ) u_chk (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .sample    (chk_sample),
    .bit_in    (data_in),
    .cfg       (cfg),
    .len_mask  (len_mask),
    .err_clear (err_clear),
    .in_sync   (in_sync),
    .err_count (err_count)
  );

  always_ff @(posedge clk) begin
    if (rst) data_out <= 1'b0;
    else     data_out <= gen_adv ? gen_bit : data_in;
  end
endmodule

// File: rtl/frac_prbs_sva.sv
module frac_prbs_sva #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             gen_en,
  input logic             chk_en,
  input logic             slot_sel,
  input logic             data_in,
  input logic             data_out,
  input logic             restart,
  input logic             err_clear,
  input logic             in_sync,
  input logic [CNT_W-1:0] err_count
);
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    !(gen_en && slot_sel) |=> data_out == $past(data_in)); // R2
  AST_RESTART_UNSYNC: assert property (@(posedge clk) disable iff (rst)
    restart |=> !in_sync); // R8
  AST_SYNC_NEEDS_CHK: assert property (@(posedge clk) disable iff (rst)
    $rose(in_sync) |-> $past(chk_en)); // R8
  AST_NO_COUNT_UNSYNC: assert property (@(posedge clk) disable iff (rst)
    (!in_sync && !err_clear) |=> $stable(err_count)); // R9
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!err_clear && err_count != '1) |=> (err_count - $past(err_count)) <= CNT_W'(1)); // R9
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    err_clear |=> err_count == '0); // R11
  AST_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (err_count == '1 && !err_clear) |=> err_count == '1); // R12
endmodule

bind frac_prbs_engine frac_prbs_sva #(.CNT_W(CNT_W)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .gen_en    (gen_en),
  .chk_en    (chk_en),
  .slot_sel  (slot_sel),
  .data_in   (data_in),
  .data_out  (data_out),
  .restart   (restart),
  .err_clear (err_clear),
  .in_sync   (in_sync),
  .err_count (err_count)
);

// File: tb/tb_frac_prbs_engine.sv
module tb_frac_prbs_engine;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;

  logic clk = 1'b0, rst = 1'b1, frame_pulse = 1'b0, data_in = 1'b0;
  logic gen_en = 1'b0, chk_en = 1'b0, pat_mode = 1'b0, pat_invert = 1'b0;
  logic restart = 1'b0, err_clear = 1'b0;
  logic [31:0] slot_mask = '1;
  logic [5:0]  pat_len = 6'd15, pat_tap = 6'd14;
  logic [31:0] pat_word = '0;
  logic data_out, in_sync;
  logic [CNT_W-1:0] err_count;

  frac_prbs_engine #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .frame_pulse(frame_pulse), .data_in(data_in),
    .data_out(data_out), .slot_mask(slot_mask), .gen_en(gen_en), .chk_en(chk_en),
    .pat_mode(pat_mode), .pat_len(pat_len), .pat_tap(pat_tap),
    .pat_invert(pat_invert), .pat_word(pat_word), .restart(restart),
    .err_clear(err_clear), .in_sync(in_sync), .err_count(err_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, pos = 0, k = 0, ncap = 0, pass_bad = 0;
  bit refb [0:8191];
  bit cap  [0:1023];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit is_sel();
    return slot_mask[pos/8];
  endfunction

  task automatic tick(input logic d, input logic clr, input logic rs, output logic o);
    data_in = d; err_clear = clr; restart = rs; frame_pulse = (pos == 0);
    @(posedge clk); #1;
    o = data_out;
    pos = (pos + 1) % 256;
    err_clear = 1'b0; restart = 1'b0; frame_pulse = 1'b0;
  endtask

  task automatic configure(input logic m, input int len, input int tap, input logic inv,
                           input logic [31:0] word, input logic [31:0] mask,
                           input logic g, input logic c);
    logic o;
    pat_mode = m; pat_len = 6'(len); pat_tap = 6'(tap); pat_invert = inv;
    pat_word = word; slot_mask = mask; gen_en = g; chk_en = c;
    for (int n = 0; n < 8192; n++) begin
      if (m) refb[n] = word[len - 1 - (n % len)];
      else   refb[n] = (n < len) ? 1'b1 : (refb[n-len] ^ refb[n-tap]);
    end
    tick(1'b0, 1'b0, 1'b1, o);
    k = 0; ncap = 0; pass_bad = 0;
  endtask

  task automatic feed_sel(input bit flip, input bit clr);
    logic o;
    while (!is_sel()) tick(logic'($urandom % 2), 1'b0, 1'b0, o);
    tick(refb[k] ^ pat_invert ^ flip, clr, 1'b0, o);
    k++;
  endtask

  task automatic gen_sel();
    logic o, d;
    while (!is_sel()) begin
      d = logic'($urandom % 2);
      tick(d, 1'b0, 1'b0, o);
      if (o !== d) pass_bad++;
    end
    tick(logic'($urandom % 2), 1'b0, 1'b0, o);
    cap[ncap] = o; ncap++;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    check(data_out == 1'b0, "R1", "data_out in reset", data_out, 0);
    check(in_sync == 1'b0, "R1", "in_sync in reset", in_sync, 0);
    check(err_count == '0, "R1", "err_count in reset", err_count, 0);
    rst = 1'b0; pos = 0;
  endtask

  task automatic t_gen_prbs(input int len, input int tap, input logic inv,
                            input logic [31:0] mask, input string req);
    int bad_seed = 0, bad_rec = 0;
    configure(1'b0, len, tap, inv, '0, mask, 1'b1, 1'b0);
    repeat (300) gen_sel();
    check(pass_bad == 0, "R2", "unselected bits altered", pass_bad, 0);
    for (int n = 0; n < len; n++) if ((cap[n] ^ inv) != 1'b1) bad_seed++;
    check(bad_seed == 0, inv ? "R5" : "R4", "seed bits wrong", bad_seed, 0);
    for (int n = len; n < ncap; n++)
      if ((cap[n] ^ inv) != ((cap[n-len] ^ inv) ^ (cap[n-tap] ^ inv))) bad_rec++;
    check(bad_rec == 0, req, "recurrence violations", bad_rec, 0);
  endtask

  task automatic t_gen_repeat();
    int bad = 0;
    configure(1'b1, 8, 1, 1'b0, 32'h1234_56A5, 32'h00FF_0F00, 1'b1, 1'b0);
    repeat (64) gen_sel();
    for (int n = 0; n < ncap; n++) if (cap[n] != pat_word[7 - (n % 8)]) bad++;
    check(bad == 0, "R6", "repeat word mismatches", bad, 0);
  endtask

  task automatic t_gen_zero();
    int ones = 0;
    configure(1'b0, 4, 4, 1'b0, '0, '1, 1'b1, 1'b0);
    repeat (100) gen_sel();
    for (int n = 8; n < ncap; n++) if (cap[n]) ones++;
    check(ones > 0, "R7", "ones after zero state", ones, 1);
  endtask

  task automatic t_sync_and_errors();
    int base, held;
    configure(1'b0, 15, 14, 1'b0, '0, 32'hF0F0_0F0F, 1'b0, 1'b1);
    repeat (40) feed_sel(1'b0, 1'b0);
    check(in_sync == 1'b0, "R8", "sync too early", in_sync, 0);
    repeat (25) feed_sel(1'b0, 1'b0);
    check(in_sync == 1'b1, "R8", "sync after 48 good bits", in_sync, 1);
    check(err_count == 0, "R9", "count while training", err_count, 0);
    for (int e = 0; e < 3; e++) begin
      repeat (29) feed_sel(1'b0, 1'b0);
      feed_sel(1'b1, 1'b0);
    end
    check(err_count == 3, "R9", "single errors counted", err_count, 3);
    check(in_sync == 1'b1, "R9", "sync kept with few errors", in_sync, 1);
    repeat (70) feed_sel(1'b0, 1'b0);
    base = err_count;
    repeat (20) feed_sel(1'b1, 1'b0);
    check(in_sync == 1'b0, "R10", "sync lost on error burst", in_sync, 0);
    check((err_count - base) >= 6 && (err_count - base) <= 11, "R10",
          "errors counted before loss", err_count - base, 6);
    held = err_count;
    repeat (10) feed_sel(1'b1, 1'b0);
    check(err_count == held, "R9", "count while out of sync", err_count, held);
    repeat (65) feed_sel(1'b0, 1'b0);
    check(in_sync == 1'b1, "R10", "resync after reseed", in_sync, 1);
    feed_sel(1'b0, 1'b1);
    check(err_count == 0, "R11", "clear", err_count, 0);
    feed_sel(1'b1, 1'b1);
    check(err_count == 0, "R11", "clear wins over error", err_count, 0);
    repeat (30) feed_sel(1'b0, 1'b0);
    feed_sel(1'b1, 1'b0);
    check(err_count == 1, "R9", "count after clear", err_count, 1);
    configure(1'b0, 15, 14, 1'b0, '0, '1, 1'b0, 1'b1);
    check(in_sync == 1'b0, "R8", "restart drops sync", in_sync, 0);
  endtask

  task automatic t_chk_modes();
    logic o;
    configure(1'b0, 9, 5, 1'b1, '0, '1, 1'b0, 1'b1);
    repeat (60) feed_sel(1'b0, 1'b0);
    check(in_sync == 1'b1, "R5", "sync to inverted stream", in_sync, 1);
    configure(1'b1, 8, 1, 1'b0, 32'h0000_00A5, 32'h3C3C_3C3C, 1'b0, 1'b1);
    repeat (60) feed_sel(1'b0, 1'b0);
    check(in_sync == 1'b1, "R6", "sync to repeat word", in_sync, 1);
    configure(1'b0, 15, 14, 1'b0, '0, '1, 1'b0, 1'b1);
    repeat (200) tick(1'b0, 1'b0, 1'b0, o);
    check(in_sync == 1'b0, "R7", "no sync on all zeros", in_sync, 0);
  endtask

  task automatic t_saturate();
    configure(1'b0, 15, 14, 1'b0, '0, '1, 1'b0, 1'b1);
    feed_sel(1'b0, 1'b1);
    repeat (65) feed_sel(1'b0, 1'b0);
    repeat (270) begin
      repeat (19) feed_sel(1'b0, 1'b0);
      feed_sel(1'b1, 1'b0);
    end
    check(err_count == 8'hFF, "R12", "saturated count", err_count, 255);
    check(in_sync == 1'b1, "R12", "sync during saturation run", in_sync, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_gen_prbs(15, 14, 1'b0, 32'h0F0F_00F3, "R3");
    t_gen_prbs(9, 5, 1'b1, 32'hFFFF_0000, "R5");
    t_gen_repeat();
    t_gen_zero();
    t_sync_and_errors();
    t_chk_modes();
    t_saturate();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule